// File: doc/BRIEF.md
# Programmable-Priority Vectored Interrupt Controller

The controller watches 32 level-sensitive interrupt lines and evaluates them through 32 ordered priority slots. Firmware can point each slot at any source line. A slot can be enabled, can invert the polarity of the line it watches, and can be marked as the fast-interrupt slot. Priority comes only from the slot position: slot 0 ranks highest and slot 31 ranks lowest. So the priority of a source is set by the slot it is mapped into, not by its line number.

Two registered outputs request service. `irq_o` is high when any enabled normal slot is active. `fiq_o` is high when the fast-interrupt slot is active. A vector register records which slot won the normal-interrupt arbitration. It is frozen while `irq_o` is high, so a handler sees a stable value. Firmware may also overwrite it. The slot configurations and the vector register sit behind a simple word-addressed register bus. Read data is returned one cycle after the read strobe.

Top module: `prio_vec_intc`

## Requirements
- R1: After reset, every slot configuration byte reads 0 (all slots disabled), `irq_o` and `fiq_o` are 0, and the vector register reads 0.
- R2: Word addresses 0 to 7 hold the slot bytes. Slot 4k+j sits in bits [8j+7:8j] of word k. Within a byte, bits [4:0] are the source line number, bit 7 is the enable, bit 6 is the invert control and bit 5 is the fast-interrupt select. A slot with bit 7 cleared has no effect on either output.
- R3: When bit 6 of a slot is 1, the slot is active while its selected line is low, not while it is high.
- R4: `irq_o` rises on the first clock edge at which an enabled normal slot (bit 5 = 0) is active. It falls on the first edge at which no such slot is active.
- R5: Slot 0 with bits 7 and 5 set drives `fiq_o` with the same one-edge timing as R4, and it does not drive `irq_o`.
- R6: A slot other than slot 0 with bit 5 set drives neither output.
- R7: The vector register (word address 8, bits [5:0]) reads {bit 5 = 1, bits [4:0] = index of the lowest-numbered active normal slot}. It is loaded on the same edge at which `irq_o` rises. While no normal slot is active and `irq_o` is low, it reads 0.
- R8: While `irq_o` is high, the vector register keeps its value, even when a higher-priority slot becomes active. It follows the arbitration again on the edge after `irq_o` falls.
- R9: A bus write to word address 8 loads bits [5:0] of the write data into the vector register. This takes precedence over both holding and updating.
- R10: Read data appears on `bus_rdata_o` on the edge that takes the read strobe and is held afterwards. Addresses 9 to 15 read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 32 | Level-sensitive interrupt source lines |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 4 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
A corrupted slot byte shows up at once in the register read-back, one cycle after the read strobe. A wrong source, enable or polarity decode makes `irq_o` or `fiq_o` wrong on the edge after the line changes. A broken priority encoder or hold path shows up on the next vector read. It is most visible when a higher-priority slot fires while `irq_o` is already high, and in the two edges after `irq_o` falls, where the vector must first stay frozen and then clear.

// File: rtl/pvic_pkg.sv
package pvic_pkg;

    localparam int unsigned SLOT_CFG_W = 8;
    localparam int unsigned ID_W       = 5;
    localparam int unsigned N_SRC      = 2 ** ID_W;

    // One priority slot: enable, polarity, fast-interrupt select, source line
    typedef struct packed {
        logic            en;
        logic            inv;
        logic            fast;
        logic [ID_W-1:0] id;
    } slot_cfg_t;

endpackage

// File: rtl/pvic_cfg_regs.sv
module pvic_cfg_regs
    import pvic_pkg::*;
#(
    parameter int unsigned N_SLOTS = 32,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ADDR_W  = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en_i,
    input  logic [ADDR_W-1:0]             addr_i,
    input  logic [DATA_W-1:0]             wdata_i,
    output slot_cfg_t [N_SLOTS-1:0]       cfg_o
);
    localparam int unsigned SPW     = DATA_W / SLOT_CFG_W;
    localparam int unsigned N_WORDS = N_SLOTS / SPW;

    typedef struct packed {
        slot_cfg_t [N_SLOTS-1:0] cfg;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int w = 0; w < N_WORDS; w++) begin
            if (wr_en_i && addr_i == ADDR_W'(w)) begin
                for (int j = 0; j < SPW; j++) begin
                    st_d.cfg[w*SPW + j] = slot_cfg_t'(wdata_i[j*SLOT_CFG_W +: SLOT_CFG_W]);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_o = st_q.cfg;

    // R10: writes outside the slot words leave every slot untouched
    p_unmapped_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i >= ADDR_W'(N_WORDS)) |=> $stable(st_q));

endmodule

// File: rtl/pvic_slot_eval.sv
module pvic_slot_eval
    import pvic_pkg::*;
#(
    parameter int unsigned N_SLOTS = 32
) (
    input  slot_cfg_t [N_SLOTS-1:0] cfg_i,
    input  logic [N_SRC-1:0]        src_i,
    output logic [N_SLOTS-1:0]      irq_req_o,
    output logic                    fiq_req_o
);
    logic [N_SLOTS-1:0] active;

    for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
        // selected line, optionally complemented, gated by enable
        assign active[s] = cfg_i[s].en & (src_i[cfg_i[s].id] ^ cfg_i[s].inv);
        if (s == 0) begin : g_top
            assign irq_req_o[s] = active[s] & ~cfg_i[s].fast;
            assign fiq_req_o    = active[s] &  cfg_i[s].fast;
        end else begin : g_rest
            // fast select is only legal on slot 0; elsewhere the slot is muted
            assign irq_req_o[s] = active[s] & ~cfg_i[s].fast;
        end
    end

endmodule

// File: rtl/pvic_prio_enc.sv
module pvic_prio_enc #(
    parameter int unsigned N     = 32,
    localparam int unsigned IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        // scan downwards so the lowest requesting index is written last
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                any_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
    import pvic_pkg::*;
#(
    parameter int unsigned N_SLOTS = 32,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ADDR_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       src_i,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_o,
    output logic              fiq_o
);
    localparam int unsigned SPW     = DATA_W / SLOT_CFG_W;
    localparam int unsigned N_WORDS = N_SLOTS / SPW;
    localparam int unsigned IDX_W   = $clog2(N_SLOTS);
    localparam int unsigned VEC_W   = IDX_W + 1;
    localparam logic [ADDR_W-1:0] VEC_ADDR = ADDR_W'(N_WORDS);

    typedef struct packed {
        logic              irq;
        logic              fiq;
        logic [VEC_W-1:0]  vec;
        logic [DATA_W-1:0] rdata;
    } top_state_t;

    top_state_t st_d, st_q;

    slot_cfg_t [N_SLOTS-1:0] cfg;
    logic [N_SLOTS-1:0]      irq_req;
    logic                    fiq_req;
    logic                    win_any;
    logic [IDX_W-1:0]        win_idx;
    logic                    bus_write, bus_read, vec_write;

    assign bus_write = bus_sel_i &  bus_wr_i;
    assign bus_read  = bus_sel_i & ~bus_wr_i;
    assign vec_write = bus_write && (bus_addr_i == VEC_ADDR);

    pvic_cfg_regs #(.N_SLOTS(N_SLOTS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en_i(bus_write),
        .addr_i (bus_addr_i),
        .wdata_i(bus_wdata_i),
        .cfg_o  (cfg)
    );

    pvic_slot_eval #(.N_SLOTS(N_SLOTS)) u_eval (
        .cfg_i    (cfg),
        .src_i    (src_i),
        .irq_req_o(irq_req),
        .fiq_req_o(fiq_req)
    );

    pvic_prio_enc #(.N(N_SLOTS)) u_enc (
        .req_i(irq_req),
        .any_o(win_any),
        .idx_o(win_idx)
    );

    always_comb begin
        st_d     = st_q;
        st_d.irq = win_any;
        st_d.fiq = fiq_req;

        if (vec_write)       st_d.vec = bus_wdata_i[VEC_W-1:0];
        else if (!st_q.irq)  st_d.vec = {win_any, win_idx};

        if (bus_read) begin
            st_d.rdata = '0;
            for (int w = 0; w < N_WORDS; w++) begin
                if (bus_addr_i == ADDR_W'(w)) begin
                    for (int j = 0; j < SPW; j++) begin
                        st_d.rdata[j*SLOT_CFG_W +: SLOT_CFG_W] = cfg[w*SPW + j];
                    end
                end
            end
            if (bus_addr_i == VEC_ADDR) st_d.rdata = DATA_W'(st_q.vec);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o       = st_q.irq;
    assign fiq_o       = st_q.fiq;
    assign bus_rdata_o = st_q.rdata;

    // R4: a pending normal request shows on irq_o after one edge
    p_irq_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_req) |=> irq_o);
    p_irq_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(|irq_req) |=> !irq_o);

    // R5: fiq_o only follows slot 0 configured as fast and enabled
    p_fiq_slot0_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o |-> ($past(cfg[0].en) && $past(cfg[0].fast)));

    // R8: vector frozen while irq_o is high and nobody writes it
    p_vec_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !vec_write) |=> $stable(st_q.vec));

    // R7: a rising irq_o comes with a valid vector
    p_vec_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_o) && !$past(vec_write)) |-> st_q.vec[VEC_W-1]);

endmodule

// File: tb/prio_vec_intc_tb_top.sv
module prio_vec_intc_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;
    logic        sel = 1'b0, wr = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, fiq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    prio_vec_intc dut_i (
        .clk(clk), .rst_n(rst_n), .src_i(src),
        .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .irq_o(irq), .fiq_o(fiq)
    );

    typedef struct packed {
        logic [31:0] w0;
        logic [31:0] w1;
        logic [31:0] srcv;
        logic        eirq;
        logic        efiq;
        logic [5:0]  evec;
    } tv_t;

    localparam int NTV = 10;
    localparam tv_t TV [NTV] = '{
        '{32'h0000_0083, 32'h0, 32'h0000_0008, 1'b1, 1'b0, 6'h20}, // R2 slot0 src3
        '{32'h0000_8500, 32'h0, 32'h0000_00A0, 1'b1, 1'b0, 6'h21}, // R2 slot1 src5
        '{32'h0089_0000, 32'h0000_8A00, 32'h0000_0600, 1'b1, 1'b0, 6'h22}, // R7 slot2 beats slot5
        '{32'h0089_0000, 32'h0000_8A00, 32'h0000_0400, 1'b1, 1'b0, 6'h25}, // R7 slot5 alone
        '{32'h0000_000C, 32'h0, 32'h0000_1000, 1'b0, 1'b0, 6'h00}, // R2 disabled slot
        '{32'h0000_00C4, 32'h0, 32'h0000_0010, 1'b0, 1'b0, 6'h20}, // R3 inverted, line high
        '{32'h0000_00A7, 32'h0, 32'h0000_0080, 1'b0, 1'b1, 6'h00}, // R5 fast slot0
        '{32'h00A7_0000, 32'h0, 32'h0000_0080, 1'b0, 1'b0, 6'h00}, // R6 fast on slot2
        '{32'h8800_00A7, 32'h0, 32'h0000_0180, 1'b1, 1'b1, 6'h23}, // R5 fast + normal slot3
        '{32'h9F00_0000, 32'h0, 32'h8000_0000, 1'b1, 1'b0, 6'h23}  // R2 source 31
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [3:0] a, logic [31:0] d);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_read(logic [3:0] a, output logic [31:0] d);
        sel = 1'b1; wr = 1'b0; addr = a;
        @(negedge clk);
        sel = 1'b0;
        d = rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 irq", {31'b0, irq}, 32'h0);
        check("R1 fiq", {31'b0, fiq}, 32'h0);
        for (int a = 0; a < 9; a++) begin
            bus_read(4'(a), rd);
            check("R1 reg", rd, 32'h0);
        end

        // table of vectors
        for (int t = 0; t < NTV; t++) begin
            src = '0;
            bus_write(4'd0, TV[t].w0);
            bus_write(4'd1, TV[t].w1);
            repeat (3) @(negedge clk);
            src = TV[t].srcv;
            @(negedge clk);
            check("R4 irq", {31'b0, irq}, {31'b0, TV[t].eirq});
            check("R5 fiq", {31'b0, fiq}, {31'b0, TV[t].efiq});
            bus_read(4'd8, rd);
            check("R7 vector", rd, {26'b0, TV[t].evec});
            bus_read(4'd0, rd);
            check("R2 word0", rd, TV[t].w0);
            bus_read(4'd1, rd);
            check("R2 word1", rd, TV[t].w1);
        end

        // R7 boundary: slot 31
        src = '0;
        bus_write(4'd0, 32'h0);
        bus_write(4'd1, 32'h0);
        bus_write(4'd7, 32'h8100_0000);
        repeat (3) @(negedge clk);
        src = 32'h2;
        @(negedge clk);
        check("R4 irq slot31", {31'b0, irq}, 32'h1);
        bus_read(4'd8, rd);
        check("R7 vector slot31", rd, 32'h3F);

        // R8: higher-priority slot arrives while irq_o is high
        bus_write(4'd0, 32'h0000_0082);
        src = 32'h6;
        repeat (2) @(negedge clk);
        check("R8 irq held", {31'b0, irq}, 32'h1);
        bus_read(4'd8, rd);
        check("R8 vector held", rd, 32'h3F);

        // R9: firmware overwrite of the vector
        bus_write(4'd8, 32'hFFFF_FFC5);
        bus_read(4'd8, rd);
        check("R9 vector write", rd, 32'h05);

        // R4 fall, R8 release
        src = '0;
        @(negedge clk);
        check("R4 irq fall", {31'b0, irq}, 32'h0);
        bus_read(4'd8, rd);
        check("R8 vector frozen on fall edge", rd, 32'h05);
        bus_read(4'd8, rd);
        check("R8 vector released", rd, 32'h00);

        // R10: unmapped addresses
        bus_write(4'd9, 32'hFFFF_FFFF);
        bus_read(4'd9, rd);
        check("R10 unmapped read", rd, 32'h0);
        bus_read(4'd0, rd);
        check("R10 word0 untouched", rd, 32'h0000_0082);
        bus_read(4'd7, rd);
        check("R10 word7 untouched", rd, 32'h8100_0000);
        bus_read(4'd8, rd);
        check("R10 vector untouched", rd, 32'h0);
        // R10: rdata holds after the strobe
        @(negedge clk);
        check("R10 rdata held", rdata, 32'h0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule